// File: doc/BRIEF.md
# Redundant PWM Pulse-Width Selector

This block sits between the per-lane fault filters and the final voter of a redundant PWM controller. Every lane carries its own copy of the same PWM waveform. Over each switching period the block counts how many clocks each lane spends high. At the next period boundary it picks one trusted width from those counts. It then builds a gate that is high from the start of the new period for exactly that many clocks, and ANDs the gate with every lane. Any pulse that runs longer than the trusted width is cut short, and shorter pulses pass unchanged.

A lane can be trusted only when its count lies close to an expected duty value, which is predicted elsewhere from the sensed supply voltage. When several lanes qualify, lanes that also agree with the previously accepted width come first. When no lane qualifies, the last good width stays in force and the valid flag drops for that period. The width chosen at a boundary comes from the period that just ended. The gating therefore always runs one period behind the measurement.

Every pin is a plain sampled signal. The block accepts a PWM sample and a strobe on every clock and never stalls. It exerts no back-pressure, and the logic downstream cannot hold it off.

Top module: `pwm_width_sel`

## Requirements
- R1: While reset is asserted and right after it, `sel_width` is 0, `sel_valid` is 0 and all `pwm_gated` bits are 0.
- R2: The width of a lane is the number of clocks on which its input is sampled high, counted from the clock on which `period_strb` is high through the clock just before the next strobe. The count saturates at 2^WBITS-1 (255 by default).
- R3: `sel_width` and `sel_valid` change only on a clock edge at which `period_strb` is sampled high. On every other edge they hold their values.
- R4: A lane qualifies at a strobe when |width − expect_duty| ≤ TOL, with the bound inclusive and TOL = 2 by default. A width of expect±2 is accepted and expect±3 is rejected. The `expect_duty` value used is the one sampled at that strobe.
- R5: The selection has two tiers. The first tier holds the qualifying lanes that are also within TOL of the width accepted before the strobe, and the lowest index among them wins. If that tier is empty, the lowest-index qualifying lane wins. The accepted width resets to 0.
- R6: If no lane qualifies, `sel_valid` goes to 0 and `sel_width` keeps its previous value.
- R7: Number the samples of a period j = 0, 1, … starting at the strobe clock, and let W be the width chosen at that strobe. `pwm_gated[i]` is high one clock after sample j exactly when `pwm_in[i]` was high at that sample and j < W. A lane therefore passes at most W high clocks per period, and none when W is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_strb | input | 1 | High on the first clock of each PWM period |
| pwm_in | input | LANES (3) | Filtered PWM bit from each redundant lane |
| expect_duty | input | WBITS (8) | Duty predicted from the supply voltage, in clocks |
| sel_width | output | WBITS (8) | Accepted pulse width in clocks |
| sel_valid | output | 1 | At least one lane qualified at the last strobe |
| pwm_gated | output | LANES (3) | Each lane ANDed with the width gate, registered |

## Verification
The hardest case to reach is the second selection tier. It needs a lane that matches the expected duty but disagrees with the previously accepted width, and no lane may agree with both. Because the accepted width always comes from an earlier period, the stimulus first walks that width to a known value (30, then 32). It then sends periods whose lane widths are placed two and three clocks either side of both references. With these widths a higher-index lane can be forced to beat a lower one, and the pure fallback case can be forced too. Saturation is reached with periods longer than 255 clocks, so the counter and the gate position both reach their ceiling.

// File: rtl/pwsel_pkg.sv
package pwsel_pkg;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_EXP  = 2'd1,
    PICK_BOTH = 2'd2
  } pick_tier_e;

  // inclusive distance test between two widths
  function automatic bit pw_within(int a, int b, int tol);
    int d;
    d = (a >= b) ? (a - b) : (b - a);
    return d <= tol;
  endfunction

endpackage

// File: rtl/pw_meter.sv
module pw_meter #(
  parameter int LANES = 3,
  parameter int WBITS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   period_strb,
  input  logic [LANES-1:0]       pwm_in,
  output logic [LANES*WBITS-1:0] width_o
);
  localparam logic [WBITS-1:0] WMAX = '1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WBITS-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (period_strb) begin
        cnt <= pwm_in[g] ? WBITS'(1) : '0;
      end else if (pwm_in[g] && (cnt != WMAX)) begin
        cnt <= cnt + WBITS'(1);
      end
    end
    assign width_o[g*WBITS +: WBITS] = cnt;
  end

endmodule

// File: rtl/pw_pick.sv
module pw_pick
  import pwsel_pkg::*;
#(
  parameter int LANES = 3,
  parameter int WBITS = 8,
  parameter int TOL   = 2
) (
  input  logic [LANES*WBITS-1:0] width_i,
  input  logic [WBITS-1:0]       expect_i,
  input  logic [WBITS-1:0]       prev_i,
  output logic [WBITS-1:0]       pick_w,
  output pick_tier_e             tier
);
  logic [WBITS-1:0] w_exp, w_both;
  logic             f_exp, f_both;

  always_comb begin
    w_exp  = '0;
    w_both = '0;
    f_exp  = 1'b0;
    f_both = 1'b0;
    // descending scan: the last hit written is the lowest index
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pw_within(int'(width_i[i*WBITS +: WBITS]), int'(expect_i), TOL)) begin
        f_exp = 1'b1;
        w_exp = width_i[i*WBITS +: WBITS];
        if (pw_within(int'(width_i[i*WBITS +: WBITS]), int'(prev_i), TOL)) begin
          f_both = 1'b1;
          w_both = width_i[i*WBITS +: WBITS];
        end
      end
    end
    if (f_both) begin
      tier   = PICK_BOTH;
      pick_w = w_both;
    end else if (f_exp) begin
      tier   = PICK_EXP;
      pick_w = w_exp;
    end else begin
      tier   = PICK_NONE;
      pick_w = prev_i;
    end
  end

endmodule

// File: rtl/pw_gate.sv
module pw_gate #(
  parameter int LANES = 3,
  parameter int WBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_strb,
  input  logic [LANES-1:0] pwm_in,
  input  logic [WBITS-1:0] width_now,
  input  logic [WBITS-1:0] width_new,
  output logic [LANES-1:0] pwm_gated
);
  localparam logic [WBITS-1:0] WMAX = '1;

  logic [WBITS-1:0] pos;
  logic             open_w;

  // sample 0 of a period uses the width being chosen at this same edge
  assign open_w = period_strb ? (width_new != '0) : (pos < width_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (period_strb) begin
      pos <= WBITS'(1);
    end else if (pos != WMAX) begin
      pos <= pos + WBITS'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_gated <= '0;
    else        pwm_gated <= pwm_in & {LANES{open_w}};
  end

endmodule

// File: rtl/pwm_width_sel.sv
module pwm_width_sel
  import pwsel_pkg::*;
#(
  parameter int LANES = 3,
  parameter int WBITS = 8,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_strb,
  input  logic [LANES-1:0] pwm_in,
  input  logic [WBITS-1:0] expect_duty,
  output logic [WBITS-1:0] sel_width,
  output logic             sel_valid,
  output logic [LANES-1:0] pwm_gated
);
  logic [LANES*WBITS-1:0] widths;
  logic [WBITS-1:0]       pick_w;
  pick_tier_e             tier;

  pw_meter #(.LANES(LANES), .WBITS(WBITS)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_strb(period_strb),
    .pwm_in     (pwm_in),
    .width_o    (widths)
  );

  pw_pick #(.LANES(LANES), .WBITS(WBITS), .TOL(TOL)) u_pick (
    .width_i (widths),
    .expect_i(expect_duty),
    .prev_i  (sel_width),
    .pick_w  (pick_w),
    .tier    (tier)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_width <= '0;
      sel_valid <= 1'b0;
    end else if (period_strb) begin
      sel_width <= pick_w;
      sel_valid <= (tier != PICK_NONE);
    end
  end

  pw_gate #(.LANES(LANES), .WBITS(WBITS)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_strb(period_strb),
    .pwm_in     (pwm_in),
    .width_now  (sel_width),
    .width_new  (pick_w),
    .pwm_gated  (pwm_gated)
  );

endmodule

// File: rtl/pwsel_chk.sv
module pwsel_chk
  import pwsel_pkg::*;
#(
  parameter int LANES = 3,
  parameter int WBITS = 8,
  parameter int TOL   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             period_strb,
  input logic [LANES-1:0] pwm_in,
  input logic [WBITS-1:0] expect_duty,
  input logic [WBITS-1:0] sel_width,
  input logic             sel_valid,
  input logic [LANES-1:0] pwm_gated
);
  logic [WBITS-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           exp_q <= '0;
    else if (period_strb) exp_q <= expect_duty;
  end

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_strb |=> ($stable(sel_width) && $stable(sel_valid)));

  // R6
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_strb |=> (sel_valid || (sel_width == $past(sel_width))));

  // R4
  accept_tol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_strb |=> (!sel_valid || pw_within(int'(sel_width), int'(exp_q), TOL)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R7
    gate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_gated[g] |-> $past(pwm_in[g]));
  end

endmodule

bind pwm_width_sel pwsel_chk #(.LANES(LANES), .WBITS(WBITS), .TOL(TOL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .period_strb(period_strb),
  .pwm_in     (pwm_in),
  .expect_duty(expect_duty),
  .sel_width  (sel_width),
  .sel_valid  (sel_valid),
  .pwm_gated  (pwm_gated)
);

// File: tb/sim_pwm_width_sel.sv
module sim_pwm_width_sel;
  localparam int LANES = 3;
  localparam int WBITS = 8;
  localparam int TOL   = 2;
  localparam int WMAX  = 255;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             period_strb = 1'b0;
  logic [LANES-1:0] pwm_in = '0;
  logic [WBITS-1:0] expect_duty = '0;
  logic [WBITS-1:0] sel_width;
  logic             sel_valid;
  logic [LANES-1:0] pwm_gated;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int m_cnt[LANES];
  int m_w, m_pos;
  bit m_v;
  bit m_g[LANES];

  always #5 clk = ~clk;

  pwm_width_sel #(.LANES(LANES), .WBITS(WBITS), .TOL(TOL)) u0 (
    .clk(clk), .rst_n(rst_n), .period_strb(period_strb), .pwm_in(pwm_in),
    .expect_duty(expect_duty), .sel_width(sel_width), .sel_valid(sel_valid),
    .pwm_gated(pwm_gated)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit near(int a, int b);
    return ((a >= b) ? a - b : b - a) <= TOL;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < LANES; i++) begin m_cnt[i] = 0; m_g[i] = 0; end
    m_w = 0; m_v = 0; m_pos = 0;
  endtask

  task automatic model_step(bit s, logic [LANES-1:0] p, int e);
    int nw;
    bit nv;
    if (s) begin
      nw = m_w; nv = 0;
      for (int i = 0; i < LANES; i++)
        if (!nv && near(m_cnt[i], e) && near(m_cnt[i], m_w)) begin nw = m_cnt[i]; nv = 1; end
      for (int i = 0; i < LANES; i++)
        if (!nv && near(m_cnt[i], e)) begin nw = m_cnt[i]; nv = 1; end
      for (int i = 0; i < LANES; i++) begin
        m_g[i] = p[i] && (nw > 0);
        m_cnt[i] = p[i] ? 1 : 0;
      end
      m_pos = 1; m_w = nw; m_v = nv;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        m_g[i] = p[i] && (m_pos < m_w);
        if (p[i] && m_cnt[i] < WMAX) m_cnt[i]++;
      end
      if (m_pos < WMAX) m_pos++;
    end
  endtask

  task automatic compare();
    chk("R3 sel_width track", int'(sel_width), m_w);
    chk("R6 sel_valid track", int'(sel_valid), int'(m_v));
    for (int i = 0; i < LANES; i++) chk("R7 gated track", int'(pwm_gated[i]), int'(m_g[i]));
  endtask

  task automatic cycle(bit s, logic [LANES-1:0] p, int e);
    @(negedge clk);
    compare();
    period_strb = s;
    pwm_in = p;
    expect_duty = e[WBITS-1:0];
    model_step(s, p, e);
  endtask

  // one PWM period; checks the selection made at its strobe and the gated counts
  task automatic run_period(int len, int w0, int w1, int w2, int e,
                            int cw, int cv, int gw, string tag);
    int gc[LANES];
    int wl[LANES];
    wl[0] = w0; wl[1] = w1; wl[2] = w2;
    for (int i = 0; i < LANES; i++) gc[i] = 0;
    for (int j = 0; j < len; j++) begin
      logic [LANES-1:0] p;
      for (int i = 0; i < LANES; i++) p[i] = (j < wl[i]);
      cycle(j == 0, p, e);
      if (j >= 1) for (int i = 0; i < LANES; i++) gc[i] += int'(pwm_gated[i]);
      if (j == 1) begin
        chk({tag, " width"}, int'(sel_width), cw);
        chk({tag, " valid"}, int'(sel_valid), cv);
      end
    end
    for (int i = 0; i < LANES; i++)
      chk({"R7 gated count ", tag}, gc[i], (wl[i] < gw) ? wl[i] : gw);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset width", int'(sel_width), 0);
    chk("R1 reset valid", int'(sel_valid), 0);
    chk("R1 reset gated", int'(pwm_gated), 0);
    rst_n = 1'b1;
    model_step(1'b0, '0, 0);
    repeat (4) cycle(1'b0, '0, 0);
    chk("R1 idle width", int'(sel_width), 0);

    run_period(100, 30, 30, 30, 30,   0, 0,   0, "R6 first strobe none");
    run_period(100, 30, 30, 30, 30,  30, 1,  30, "R2 R4 width 30");
    run_period(100, 10, 30, 30, 30,  30, 1,  30, "R4 after equal lanes");
    run_period(100, 80, 30, 30, 30,  30, 1,  30, "R5 short lane0 skipped");
    run_period(100, 33, 32, 30, 30,  30, 1,  30, "R5 long lane0 skipped");
    run_period(100, 28, 34, 27, 30,  32, 1,  32, "R4 plus2 kept plus3 dropped");
    run_period(100, 31, 29,  0, 30,  28, 1,  28, "R5 expect-only fallback");
    run_period(100,  0,  0,  0, 30,  29, 1,  29, "R5 both-tier beats lower index");
    run_period(100,  0,  0,  0, 30,  29, 0,  29, "R6 none holds width");
    run_period(300, 270, 270, 270, 255, 29, 0, 29, "R6 still holding");
    run_period(300, 280, 280, 280, 255, 255, 1, 255, "R2 saturated width");
    run_period(100,  0,  0,  0, 30, 255, 0, 255, "R6 hold after saturation");
    repeat (3) cycle(1'b0, '0, 30);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule